// File: doc/BRIEF.md
# ROM-Driven SPI Configuration Sequencer

After reset, external devices such as a clock generator and two data converters have to be configured before the rest of the system leaves reset. This block handles that job. A start pulse makes it walk a small synchronous initialization ROM from address 0 upward. Each 32-bit entry is sent as one SPI write transaction on a 4-wire bus, with the block acting as bus master.

Each entry has three fields. The top octet selects which downstream target takes the frame. The next 16 bits are the device instruction (write direction plus register address). The low octet is the data byte. The ROM's order is the configuration order, so clock-generator writes are placed ahead of the converter writes.

The sequence stops at the first all-ones entry, or after a parameterized number of entries, whichever comes first. Completion is then reported on a level output that stays high until the next start. The serial input line is present for bus completeness, but its value is never used.

Top module: `spi_cfg_seq`

## Requirements
- R1: Chip select is low for exactly 32 rising SCLK edges per transaction and stays low continuously between the first and the last of them.
- R2: Each ROM word is sent unchanged, bit 31 first and bit 0 last. Bits 31:24 form the target-select octet, bits 23:8 the instruction and bits 7:0 the data byte.
- R3: Transactions follow ROM order, starting at address 0, with the address rising by one per transaction.
- R4: SCLK is low whenever chip select is high. MOSI changes only on a falling SCLK edge, or when chip select falls. The first bit is therefore valid before the first rising edge.
- R5: The ROM clock enable is asserted only while chip select is high. There is exactly one read per entry.
- R6: Between two transactions, chip select stays high for at least CS_GAP SCLK periods (CS_GAP × CLK_DIV system clocks).
- R7: The SCLK period is CLK_DIV system clocks.
- R8: An entry equal to 32'hFFFF_FFFF is not transmitted. It ends the sequence and raises done.
- R9: After N_ENTRIES transactions, the sequence ends and done rises. No address beyond N_ENTRIES-1 is read.
- R10: Done stays high until the next start. While done is high, no transaction takes place. A start pulse during a running sequence is ignored. A start pulse after done restarts the sequence from address 0.
- R11: After reset, chip select is high, SCLK is low, done is low and the ROM clock enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to replay the ROM |
| done_o | output | 1 | Sequence complete, held until next start |
| rom_addr_o | output | ROM_AW | ROM word address |
| rom_ce_o | output | 1 | ROM clock enable; data is valid one cycle later |
| rom_data_i | input | 32 | ROM read data |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in (ignored) |

## Verification
The bound checker watches several bus rules on every cycle: the 32-edge frame length, MOSI moving only on falling SCLK, SCLK idling low, the minimum chip-select gap, ROM reads happening only between frames, and done staying high while the bus is quiet. Other behaviour can only be shown by the bench scenarios, which decode each frame and compare it with the expected word in a scoreboard. These include bit order, field placement, ROM order from address 0, the SCLK period, the two termination conditions and the highest address read, a start pulse ignored mid-sequence, and a restart after done.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned FRAME_BITS = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_SHIFT,
    ST_GAP,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0]  tgt_sel;
    logic [15:0] instr;
    logic [7:0]  wdata;
  } cfg_entry_t;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int unsigned CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!en_i)                      cnt_q <= '0;
    else if (cnt_q == CNT_W'(CLK_DIV-1)) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign rise_o = en_i && (cnt_q == CNT_W'(HALF-1));
  assign fall_o = en_i && (cnt_q == CNT_W'(CLK_DIV-1));
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int unsigned FRAME_BITS = spi_cfg_pkg::FRAME_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  output logic                  active_o,
  output logic                  fin_o,
  output logic                  sclk_o,
  output logic                  cs_no,
  output logic                  mosi_o
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q;
  logic [BIT_W-1:0]      bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      bit_q    <= '0;
      active_o <= 1'b0;
      fin_o    <= 1'b0;
      sclk_o   <= 1'b0;
      cs_no    <= 1'b1;
    end else begin
      fin_o <= 1'b0;
      if (load_i && !active_o) begin
        sr_q     <= word_i;
        bit_q    <= '0;
        active_o <= 1'b1;
        cs_no    <= 1'b0;
        sclk_o   <= 1'b0;
      end else if (active_o) begin
        if (rise_i) sclk_o <= 1'b1;
        if (fall_i) begin
          sclk_o <= 1'b0;
          if (bit_q == BIT_W'(FRAME_BITS-1)) begin
            active_o <= 1'b0;
            cs_no    <= 1'b1;
            fin_o    <= 1'b1;
            sr_q     <= '0;
          end else begin
            // next bit appears with the falling edge
            sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign mosi_o = sr_q[FRAME_BITS-1];
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ROM_AW    = 4,
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned GAP_CYC   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] rom_data_i,
  input  logic                  fin_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic                  rom_ce_o,
  output logic                  load_o,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  done_o
);
  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [ROM_AW-1:0] LAST_IDX = ROM_AW'(N_ENTRIES - 1);

  seq_state_e       state_q;
  logic [ROM_AW-1:0] idx_q;
  logic [GAP_W-1:0]  gap_q;
  cfg_entry_t        entry;
  logic              is_end;

  assign entry  = cfg_entry_t'(rom_data_i);
  assign is_end = &entry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      gap_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            idx_q   <= '0;
            done_o  <= 1'b0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LATCH;
        ST_LATCH: begin
          if (is_end) begin
            done_o  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (fin_i) begin
            if (idx_q == LAST_IDX) begin
              done_o  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              gap_q   <= '0;
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GAP_W'(GAP_CYC - 1)) state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rom_addr_o = idx_q;
  assign rom_ce_o   = (state_q == ST_FETCH);
  assign load_o     = (state_q == ST_LATCH) && !is_end;
  assign word_o     = {entry.tgt_sel, entry.instr, entry.wdata};
endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ROM_AW    = 4,
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned CLK_DIV   = 8,
  parameter int unsigned CS_GAP    = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  output logic                  done_o,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic                  rom_ce_o,
  input  logic [FRAME_BITS-1:0] rom_data_i,
  output logic                  spi_sclk_o,
  output logic                  spi_cs_no,
  output logic                  spi_mosi_o,
  input  logic                  spi_miso_i
);
  localparam int unsigned GAP_CYC = CS_GAP * CLK_DIV;

  logic                  rise, fall, active, fin, load;
  logic [FRAME_BITS-1:0] word;
  logic                  unused_miso;

  assign unused_miso = spi_miso_i;

  spi_sclk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .word_i   (word),
    .rise_i   (rise),
    .fall_i   (fall),
    .active_o (active),
    .fin_o    (fin),
    .sclk_o   (spi_sclk_o),
    .cs_no    (spi_cs_no),
    .mosi_o   (spi_mosi_o)
  );

  cfg_seq_ctrl #(
    .ROM_AW   (ROM_AW),
    .N_ENTRIES(N_ENTRIES),
    .GAP_CYC  (GAP_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rom_data_i (rom_data_i),
    .fin_i      (fin),
    .rom_addr_o (rom_addr_o),
    .rom_ce_o   (rom_ce_o),
    .load_o     (load),
    .word_o     (word),
    .done_o     (done_o)
  );
endmodule

// File: rtl/spi_cfg_seq_chk.sv
module spi_cfg_seq_chk #(
  parameter int unsigned CLK_DIV = 8,
  parameter int unsigned CS_GAP  = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic done_o,
  input logic rom_ce_o,
  input logic spi_sclk_o,
  input logic spi_cs_no,
  input logic spi_mosi_o
);
  localparam int unsigned GAP_CYC = CS_GAP * CLK_DIV;

  logic        sclk_q, cs_q, seen_frame;
  logic [6:0]  edge_cnt;
  logic [15:0] gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      seen_frame <= 1'b0;
      edge_cnt   <= '0;
      gap_cnt    <= '0;
    end else begin
      sclk_q <= spi_sclk_o;
      cs_q   <= spi_cs_no;
      if (!cs_q && spi_cs_no) seen_frame <= 1'b1;
      if (cs_q && !spi_cs_no)                        edge_cnt <= '0;
      else if (!spi_cs_no && spi_sclk_o && !sclk_q)  edge_cnt <= edge_cnt + 1'b1;
      if (!spi_cs_no)              gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> (edge_cnt == 7'd32)); // R1

  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o); // R4

  AST_MOSI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spi_cs_no && $past(!spi_cs_no) && !$fell(spi_sclk_o)) |-> $stable(spi_mosi_o)); // R4

  AST_ROM_CE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_ce_o |-> spi_cs_no); // R5

  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(spi_cs_no) && seen_frame) |-> (gap_cnt >= 16'(GAP_CYC))); // R6

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R10

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (spi_cs_no && !rom_ce_o)); // R10
endmodule

bind spi_cfg_seq spi_cfg_seq_chk #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .rom_ce_o   (rom_ce_o),
  .spi_sclk_o (spi_sclk_o),
  .spi_cs_no  (spi_cs_no),
  .spi_mosi_o (spi_mosi_o)
);

// File: tb/spi_cfg_seq_tb.sv
module spi_cfg_seq_tb;
  localparam int unsigned ROM_AW    = 3;
  localparam int unsigned N_ENTRIES = 4;
  localparam int unsigned CLK_DIV   = 8;
  localparam int unsigned CS_GAP    = 2;
  localparam logic [31:0] END_WORD  = 32'hFFFF_FFFF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              done;
  logic [ROM_AW-1:0] rom_addr;
  logic              rom_ce;
  logic [31:0]       rom_q = '0;
  logic              sclk, cs_n, mosi;
  logic              miso = 1'b0;

  logic [31:0] rom_mem [2**ROM_AW];
  logic [31:0] exp_q [$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int frames_rx = 0, max_addr = -1, n_reads = 0;

  always #5 clk = ~clk;
  initial forever #7 miso = ~miso;

  always @(posedge clk) if (rom_ce) rom_q <= rom_mem[rom_addr];

  spi_cfg_seq #(
    .ROM_AW(ROM_AW), .N_ENTRIES(N_ENTRIES), .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .rom_addr_o(rom_addr), .rom_ce_o(rom_ce), .rom_data_i(rom_q),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: decode frames, pop scoreboard
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [31:0] rx = '0;
  int          nbits = 0, rise_gap = 0, gap = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      rise_gap++;
      if (cs_n) gap++;
      if (rom_ce) begin
        n_reads++;
        if (int'(rom_addr) > max_addr) max_addr = int'(rom_addr);
        if (!cs_n) chk(1'b0, "R5 ROM read inside frame", 32'(rom_addr), '0);
      end
      if (!cs_n && prev_cs) begin
        if (frames_rx > 0) chk(gap >= int'(CS_GAP*CLK_DIV), "R6 cs gap", 32'(gap), 32'(CS_GAP*CLK_DIV));
        nbits = 0;
        rx = '0;
      end
      if (!cs_n && sclk && !prev_sclk) begin
        if (nbits > 0) chk(rise_gap == int'(CLK_DIV), "R7 sclk period", 32'(rise_gap), 32'(CLK_DIV));
        rise_gap = 0;
        rx = {rx[30:0], mosi};
        nbits++;
      end
      if (cs_n && !prev_cs) begin
        chk(nbits == 32, "R1 bits per frame", 32'(nbits), 32'd32);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", rx, '0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(rx[31:24] == e[31:24], "R2 target select octet", {24'd0, rx[31:24]}, {24'd0, e[31:24]});
          chk(rx == e, "R3 frame in ROM order", rx, e);
        end
        frames_rx++;
        gap = 0;
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  // driver: push expected frames, start, wait for done
  task automatic run_case(input string tag, input int pulse_mid);
    int exp_last, exp_frames, f0;
    exp_last   = int'(N_ENTRIES) - 1;
    exp_frames = 0;
    for (int i = 0; i < int'(N_ENTRIES); i++) begin
      if (rom_mem[i] == END_WORD) begin
        exp_last = i;
        break;
      end
      exp_q.push_back(rom_mem[i]);
      exp_frames++;
    end
    max_addr = -1;
    n_reads  = 0;
    f0       = frames_rx;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (pulse_mid != 0) begin
      while (frames_rx == f0) @(negedge clk);
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    @(negedge clk);
    chk(done, {tag, " done raised"}, 32'(done), 32'd1);
    chk(exp_q.size() == 0, {tag, " all expected frames sent"}, 32'(exp_q.size()), '0);
    chk(frames_rx - f0 == exp_frames, {tag, " frame count"}, 32'(frames_rx - f0), 32'(exp_frames));
    chk(max_addr == exp_last, {tag, " last ROM address read"}, 32'(max_addr), 32'(exp_last));
    chk(n_reads == exp_last + 1, "R5 one read per entry", 32'(n_reads), 32'(exp_last + 1));
    exp_q.delete();
    f0 = frames_rx;
    repeat (60) @(negedge clk);
    chk(done && cs_n, "R10 done held, bus quiet", {30'd0, done, cs_n}, 32'd3);
    chk(frames_rx == f0, "R10 no frame after done", 32'(frames_rx), 32'(f0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2**ROM_AW; i++) rom_mem[i] = END_WORD;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R11 reset cs_n", 32'(cs_n), 32'd1);
    chk(sclk == 1'b0, "R11 reset sclk", 32'(sclk), 32'd0);
    chk(done == 1'b0, "R11 reset done", 32'(done), 32'd0);
    chk(rom_ce == 1'b0, "R11 reset rom_ce", 32'(rom_ce), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: terminator after three entries, example entry in slot 1
    rom_mem[0] = 32'h8000_1824;
    rom_mem[1] = 32'h8100_6E01;
    rom_mem[2] = 32'h82A5_5AC3;
    rom_mem[3] = END_WORD;
    run_case("R8 terminator", 0);

    // R9: limit by entry count, patterns with alternating and edge bits
    for (int i = 0; i < 2**ROM_AW; i++) rom_mem[i] = 32'h4000_0001 ^ (32'h1357_9BDF * (i + 1));
    rom_mem[2] = 32'h0000_0001;
    rom_mem[3] = 32'hFFFF_FFFE;
    run_case("R9 entry limit", 0);

    // R8: terminator at address 0
    rom_mem[0] = END_WORD;
    run_case("R8 empty ROM", 0);

    // R10: start during run ignored, restart from address 0
    for (int i = 0; i < 2**ROM_AW; i++) rom_mem[i] = {8'h80 + 8'(i), 16'h0010 + 16'(i), 8'hA0 + 8'(i)};
    run_case("R10 start ignored while busy", 1);

    summary();
    $finish;
  end
endmodule